// File: doc/BRIEF.md
# Serial Flash Per-Sector Lock Sequencer

This block sets the write protection of a serial flash device one sector at a time, so that exactly one contiguous read-only window remains. After a start pulse it takes a window offset, a window size and the total device size. It first confirms that the window lies on sector boundaries. It then switches the device into individual-lock mode with a status register write. Finally it visits every sector of the device in ascending address order. Each sector inside the window gets a lock command and every other sector gets an unlock command.

Commands leave the block as complete frames for a downstream serial master, which handles all bit shifting and chip-select timing. A frame is held on the command port under a valid/ready handshake. The block then waits for a single response carrying an error flag before it presents the next frame. A busy level covers the whole job, and the job ends with a one-cycle done pulse or a one-cycle error pulse.

Top module: `sector_lock_seq`

## Requirements
- R1: A start whose window offset or window size is not a multiple of SECTOR_BYTES (a power of two) is rejected: err_o pulses in the cycle after start, busy_o stays low and no frame is presented.
- R2: An accepted job first presents a 2-byte frame, opcode MODE_OPCODE (default 0x11) in cmd_bytes_o[39:32] and MODE_VALUE (default 0x04, the individual-lock selection bit) in cmd_bytes_o[31:24], with cmd_len_o = 2 and cmd_rd_len_o = 0.
- R3: Every sector frame has cmd_len_o = 5 and cmd_rd_len_o = 1. Its bytes are the opcode in [39:32], then the 24-bit sector address high byte first in [31:8], then 0x00 in [7:0].
- R4: A sector whose address a satisfies offset <= a < offset+size uses the lock opcode 0x36. Every other sector uses the unlock opcode 0x39.
- R5: Sector frames cover addresses 0, S, 2S, ... in ascending order for every address below the flash size, where S = SECTOR_BYTES. As a result the unlocks below the window come first, then the locks inside it, then the unlocks above it.
- R6: cmd_valid_o and the frame stay unchanged until cmd_ready_i is sampled high. No new frame appears until the response (rsp_valid_i) for the previous frame has arrived.
- R7: A response with rsp_err_i set ends the job. err_o pulses in the next cycle, busy_o falls and no further frame is presented.
- R8: busy_o is high from the cycle after an accepted start until the job ends. done_o pulses for one cycle, with busy_o low, in the cycle after the response to the final sector frame.
- R9: A window of size zero produces no lock frame, and every sector is unlocked.
- R10: A start pulse while busy_o is high is ignored and does not change the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| region_off_i | input | ADDR_W | Byte offset of the read-only window |
| region_size_i | input | ADDR_W+1 | Byte size of the read-only window |
| flash_size_i | input | ADDR_W+1 | Total device size in bytes |
| cmd_valid_o | output | 1 | Frame valid |
| cmd_ready_i | input | 1 | Downstream accepts frame |
| cmd_bytes_o | output | 40 | Frame bytes, first byte in [39:32] |
| cmd_len_o | output | 3 | Number of bytes to transmit |
| cmd_rd_len_o | output | 1 | Number of response bytes to read |
| rsp_valid_i | input | 1 | Frame completed |
| rsp_err_i | input | 1 | Frame completed with error |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished successfully (pulse) |
| err_o | output | 1 | Job rejected or aborted (pulse) |

## Verification
The bench aims at windows that touch the bottom or the top of the device, windows that cover all of it, and zero-size windows. A design that compares the window bounds off by one would put a wrong opcode on the first or last sector. Misaligned offsets and sizes are also tested: a design that skips the check would emit frames where it should only report an error. Errors are injected on the mode frame and in the middle of the walk. These catch a design that keeps going after a failure or that raises done as well as err. A start during a running job, with misaligned inputs, exposes a design that restarts or reports an error while busy.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE_REQ,
    ST_MODE_WAIT,
    ST_SECT_REQ,
    ST_SECT_WAIT
  } seq_state_e;

  localparam logic [7:0] OP_SECT_LOCK   = 8'h36;
  localparam logic [7:0] OP_SECT_UNLOCK = 8'h39;
  localparam int         FRAME_BITS     = 40;
endpackage

// File: rtl/sls_align_chk.sv
module sls_align_chk #(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W:0]   size_i,
  output logic              aligned_o
);
  localparam logic [ADDR_W:0] LOW_MASK = (ADDR_W+1)'(SECTOR_BYTES - 1);

  logic [ADDR_W:0] off_ext;
  assign off_ext   = {1'b0, off_i};
  assign aligned_o = ((off_ext & LOW_MASK) == '0) && ((size_i & LOW_MASK) == '0);
endmodule

// File: rtl/sls_addr_walk.sv
module sls_addr_walk #(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [ADDR_W+1:0] win_lo_i,
  input  logic [ADDR_W+1:0] win_hi_i,
  input  logic [ADDR_W+1:0] limit_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic              in_win_o,
  output logic              last_o
);
  localparam int              CW   = ADDR_W + 2;
  localparam logic [CW-1:0]   STEP = CW'(SECTOR_BYTES);

  logic [CW-1:0] cur_q, cur_d, nxt_addr;
  logic          cur_en;

  assign nxt_addr = cur_q + STEP;
  assign cur_en   = clr_i | step_i;

  always_comb begin
    cur_d = cur_q;
    if (clr_i)       cur_d = '0;
    else if (step_i) cur_d = nxt_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign cur_o    = cur_q[ADDR_W-1:0];
  assign in_win_o = (cur_q >= win_lo_i) && (cur_q < win_hi_i);
  assign last_o   = (nxt_addr >= limit_i);
endmodule

// File: rtl/sls_frame_fmt.sv
module sls_frame_fmt
  import sls_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter logic [7:0] MODE_OPCODE = 8'h11,
  parameter logic [7:0] MODE_VALUE  = 8'h04
) (
  input  logic                  mode_sel_i,
  input  logic                  lock_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [FRAME_BITS-1:0] bytes_o,
  output logic [2:0]            len_o,
  output logic                  rd_len_o
);
  localparam int ADDR_BYTES = 3;

  logic [8*ADDR_BYTES-1:0] addr24;
  logic [FRAME_BITS-1:0]   sect_frame;
  logic [FRAME_BITS-1:0]   mode_frame;

  assign addr24 = (8*ADDR_BYTES)'(addr_i);

  assign sect_frame[39:32] = lock_i ? OP_SECT_LOCK : OP_SECT_UNLOCK;
  assign sect_frame[7:0]   = 8'h00;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_BYTES; gi++) begin : g_addr_byte
      assign sect_frame[31-8*gi -: 8] = addr24[8*ADDR_BYTES-1-8*gi -: 8];
    end
  endgenerate

  assign mode_frame = {MODE_OPCODE, MODE_VALUE, 24'h000000};

  always_comb begin
    if (mode_sel_i) begin
      bytes_o  = mode_frame;
      len_o    = 3'd2;
      rd_len_o = 1'b0;
    end else begin
      bytes_o  = sect_frame;
      len_o    = 3'd5;
      rd_len_o = 1'b1;
    end
  end
endmodule

// File: rtl/sector_lock_seq.sv
module sector_lock_seq
  import sls_pkg::*;
#(
  parameter int         ADDR_W       = 24,
  parameter int         SECTOR_BYTES = 4096,
  parameter logic [7:0] MODE_OPCODE  = 8'h11,
  parameter logic [7:0] MODE_VALUE   = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] region_off_i,
  input  logic [ADDR_W:0]   region_size_i,
  input  logic [ADDR_W:0]   flash_size_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [39:0]       cmd_bytes_o,
  output logic [2:0]        cmd_len_o,
  output logic              cmd_rd_len_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CW = ADDR_W + 2;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] win_lo_q, win_hi_q, limit_q;
  logic          latch_en;
  logic          done_q, done_d, err_q, err_d;
  logic          walk_clr, walk_step;
  logic          aligned, in_win, last_sect;
  logic [ADDR_W-1:0] cur_addr;

  sls_align_chk #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_align (
    .off_i    (region_off_i),
    .size_i   (region_size_i),
    .aligned_o(aligned)
  );

  sls_addr_walk #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (walk_clr),
    .step_i  (walk_step),
    .win_lo_i(win_lo_q),
    .win_hi_i(win_hi_q),
    .limit_i (limit_q),
    .cur_o   (cur_addr),
    .in_win_o(in_win),
    .last_o  (last_sect)
  );

  sls_frame_fmt #(.ADDR_W(ADDR_W), .MODE_OPCODE(MODE_OPCODE), .MODE_VALUE(MODE_VALUE)) u_fmt (
    .mode_sel_i(state_q == ST_MODE_REQ),
    .lock_i    (in_win),
    .addr_i    (cur_addr),
    .bytes_o   (cmd_bytes_o),
    .len_o     (cmd_len_o),
    .rd_len_o  (cmd_rd_len_o)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    latch_en  = 1'b0;
    walk_clr  = 1'b0;
    walk_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (aligned) begin
            latch_en = 1'b1;
            state_d  = ST_MODE_REQ;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_MODE_REQ: if (cmd_ready_i) state_d = ST_MODE_WAIT;
      ST_MODE_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_err_i) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            walk_clr = 1'b1;
            if (limit_q == '0) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_SECT_REQ;
            end
          end
        end
      end
      ST_SECT_REQ: if (cmd_ready_i) state_d = ST_SECT_WAIT;
      ST_SECT_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_err_i) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (last_sect) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            walk_step = 1'b1;
            state_d   = ST_SECT_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo_q <= '0;
      win_hi_q <= '0;
      limit_q  <= '0;
    end else if (latch_en) begin
      win_lo_q <= CW'(region_off_i);
      win_hi_q <= CW'(region_off_i) + CW'(region_size_i);
      limit_q  <= CW'(flash_size_i);
    end
  end

  assign cmd_valid_o = (state_q == ST_MODE_REQ) || (state_q == ST_SECT_REQ);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/sls_chk.sv
module sls_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [39:0] cmd_bytes_o,
  input logic [2:0]  cmd_len_o,
  input logic        cmd_rd_len_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  p_hold_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_bytes_o) && $stable(cmd_len_o)));

  p_no_frame_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!err_o && !busy_o));

  p_err_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);

  p_busy_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_sect_opcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_len_o == 3'd5) |->
      ((cmd_bytes_o[39:32] == 8'h36 || cmd_bytes_o[39:32] == 8'h39) && cmd_bytes_o[7:0] == 8'h00 && cmd_rd_len_o));

  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ((cmd_len_o == 3'd2 && !cmd_rd_len_o) || cmd_len_o == 3'd5));
endmodule

bind sector_lock_seq sls_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_bytes_o (cmd_bytes_o),
  .cmd_len_o   (cmd_len_o),
  .cmd_rd_len_o(cmd_rd_len_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/sector_lock_seq_tb.sv
module sector_lock_seq_tb;
  localparam int AW = 24;
  localparam int SB = 4096;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] r_off;
  logic [AW:0]   r_size, f_size;
  logic          cmd_valid, cmd_ready, cmd_rd_len;
  logic [39:0]   cmd_bytes;
  logic [2:0]    cmd_len;
  logic          rsp_valid, rsp_err;
  logic          busy, done, err;

  always #5 clk = ~clk;

  sector_lock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .region_off_i(r_off), .region_size_i(r_size), .flash_size_i(f_size),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_bytes_o(cmd_bytes),
    .cmd_len_o(cmd_len), .cmd_rd_len_o(cmd_rd_len),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // reference model state
  logic [43:0] exp_q[$];
  bit          mon_en = 0;
  bit          m_active = 0;
  bit          exp_busy = 0, exp_done = 0, exp_err = 0;
  bit          outstanding = 0;
  int          rsp_cnt = 0;
  int          frame_no = 0;
  int          err_at = -1;
  bit          prev_stall = 0;
  logic [39:0] prev_bytes = '0;
  logic [15:0] lfsr = 16'hACE1;
  string       tag = "R0";
  bit          req_go = 0;
  logic [AW-1:0] req_off;
  logic [AW:0]   req_size, req_fsize;

  always @(negedge clk) begin
    if (mon_en) begin
      chk(busy === exp_busy, {tag, " R8 busy"}, 64'(busy), 64'(exp_busy));
      chk(done === exp_done, {tag, " R8 done"}, 64'(done), 64'(exp_done));
      chk(err === exp_err, {tag, " R1/R7 err"}, 64'(err), 64'(exp_err));
      if (prev_stall)
        chk(cmd_valid && cmd_bytes == prev_bytes, {tag, " R6 frame held"}, 64'(cmd_bytes), 64'(prev_bytes));
      if (!m_active || outstanding)
        chk(!cmd_valid, {tag, " R6 no frame expected"}, 64'(cmd_valid), 64'd0);
      exp_done = 0;
      exp_err  = 0;
      // responder
      rsp_valid = 0;
      rsp_err   = 0;
      if (outstanding) begin
        if (rsp_cnt == 0) begin
          rsp_valid   = 1;
          outstanding = 0;
          if (frame_no - 1 == err_at) begin
            rsp_err  = 1;
            exp_err  = 1;
            exp_busy = 0;
            m_active = 0;
            exp_q.delete();
          end else if (exp_q.size() == 0) begin
            exp_done = 1;
            exp_busy = 0;
            m_active = 0;
          end
        end else begin
          rsp_cnt--;
        end
      end
      // ready and handshake
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready  = lfsr[0] | lfsr[3];
      prev_stall = cmd_valid && !cmd_ready;
      prev_bytes = cmd_bytes;
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, {tag, " R5 unexpected frame"}, 64'(cmd_bytes), 64'd0);
        end else begin
          logic [43:0] e;
          e = exp_q.pop_front();
          chk({cmd_rd_len, cmd_len, cmd_bytes} == e, {tag, " R2/R3/R4/R5 frame"},
              64'({cmd_rd_len, cmd_len, cmd_bytes}), 64'(e));
        end
        frame_no++;
        outstanding = 1;
        rsp_cnt     = int'(lfsr[5:4]);
      end
      // start request
      start = 0;
      if (req_go) begin
        req_go = 0;
        start  = 1;
        r_off  = req_off;
        r_size = req_size;
        f_size = req_fsize;
        if (m_active) begin
          // ignored while busy (R10)
        end else if ((req_off % SB) != 0 || (req_size % SB) != 0) begin
          exp_err = 1;
        end else begin
          exp_q.push_back({1'b0, 3'd2, 8'h11, 8'h04, 24'h0});
          for (int a = 0; a < int'(req_fsize); a += SB) begin
            logic [7:0] op;
            op = (a >= int'(req_off) && a < int'(req_off) + int'(req_size)) ? 8'h36 : 8'h39;
            exp_q.push_back({1'b1, 3'd5, op, 24'(a), 8'h00});
          end
          m_active = 1;
          exp_busy = 1;
          frame_no = 0;
        end
      end
    end
  end

  task automatic post(input int off, input int size, input int fsize);
    @(posedge clk);
    req_off   = AW'(off);
    req_size  = (AW+1)'(size);
    req_fsize = (AW+1)'(fsize);
    req_go    = 1;
  endtask

  task automatic job(input string t, input int off, input int size, input int fsize, input int eat);
    int exp_frames;
    @(posedge clk);
    tag    = t;
    err_at = eat;
    post(off, size, fsize);
    do @(negedge clk); while (req_go || m_active);
    repeat (3) @(negedge clk);
    if ((off % SB) != 0 || (size % SB) != 0) exp_frames = 0;
    else if (eat >= 0)                       exp_frames = eat + 1;
    else                                     exp_frames = 1 + fsize / SB;
    chk(frame_no == exp_frames, {t, " frame count"}, 64'(frame_no), 64'(exp_frames));
    frame_no = 0;
  endtask

  initial begin
    rst_n = 0; start = 0; cmd_ready = 0; rsp_valid = 0; rsp_err = 0;
    r_off = '0; r_size = '0; f_size = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err && !cmd_valid, "R8 reset state", 64'({busy, done, err, cmd_valid}), 64'd0);
    mon_en = 1;

    job("R5 middle window",  32'h4000, 32'h3000, 32'h10000, -1);
    job("R4 bottom window",  32'h0000, 32'h2000, 32'h10000, -1);
    job("R4 top window",     32'hC000, 32'h4000, 32'h10000, -1);
    job("R4 whole device",   32'h0000, 32'h10000, 32'h10000, -1);
    job("R9 empty window",   32'h3000, 32'h0000, 32'h10000, -1);
    job("R3 larger device",  32'h1F000, 32'h1000, 32'h20000, -1);
    job("R1 offset misaligned", 32'h4100, 32'h1000, 32'h10000, -1);
    job("R1 size misaligned",   32'h4000, 32'h1800, 32'h10000, -1);
    job("R7 error on mode frame", 32'h4000, 32'h1000, 32'h10000, 0);
    job("R7 error mid walk",      32'h4000, 32'h1000, 32'h10000, 5);

    // R10: second start during a running job, misaligned so acceptance would show
    @(posedge clk);
    tag    = "R10 start while busy";
    err_at = -1;
    post(32'h2000, 32'h2000, 32'h10000);
    repeat (12) @(posedge clk);
    post(32'h0100, 32'h0100, 32'h10000);
    do @(negedge clk); while (req_go || m_active);
    repeat (3) @(negedge clk);
    chk(frame_no == 17, "R10 frame count", 64'(frame_no), 64'd17);

    job("R2 after ignored start", 32'h8000, 32'h8000, 32'h10000, -1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule